// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial memory. A fast system clock oversamples the serial clock and data lines. The block recognises bus start and stop events, shifts bytes in and out, and acknowledges by pulling the data line low through an open-drain enable. Behind the bus engine sits a byte array whose size is set by a parameter. Writes are staged in a page buffer and committed when the transfer stops. A counter then simulates the self-timed programming period, and the target stays silent for its whole length.

The device byte carries a fixed prefix of `1010`, three select/page bits and a direction bit. Select bits that the array size does not need are compared with the hardwired select pins. The remaining low-order select bits become the top bits of the memory address. With the default 1024 bytes, bit 3 of the device byte is compared with `sel_i[2]`, and bits 2:1 form address bits 9:8.

The bus engine is a state machine with these states:

- `ST_IDLE` and `ST_SKIP`: waiting for a start.
- `ST_DEV`: shifting in the device byte.
- `ST_DEV_ACK`: acknowledging the device byte.
- `ST_WADR` and `ST_WADR_ACK`: receiving and acknowledging the word address.
- `ST_WDAT` and `ST_WDAT_ACK`: receiving and acknowledging data.
- `ST_RD`: driving a data byte.
- `ST_RD_ACK`: sampling the controller's answer.

Its transitions are:

- A start from any state goes to `ST_DEV`, and a stop from any state goes to `ST_IDLE`.
- At the eighth falling clock, `ST_DEV` goes to `ST_DEV_ACK` on a match while idle, and otherwise to `ST_SKIP`.
- At the falling clock, `ST_DEV_ACK` goes to `ST_RD` for a read and to `ST_WADR` for a write.
- At the eighth falling clock, `ST_WADR` goes to `ST_WADR_ACK`, and `ST_WDAT` goes to `ST_WDAT_ACK`.
- At the falling clock, `ST_WADR_ACK` and `ST_WDAT_ACK` both go to `ST_WDAT`.
- At the eighth falling clock, `ST_RD` goes to `ST_RD_ACK`.
- At the falling clock, `ST_RD_ACK` returns to `ST_RD` if the controller acknowledged, and goes to `ST_SKIP` otherwise.

Top module: `e2_target`

## Requirements
- R1: After reset `sda_oe_o` is 0. A start is a data fall while the clock is high, and a stop is a data rise while the clock is high. A start is honoured from any state.
- R2: A device byte with top nibble `1010`, whose bit 3 equals `sel_i[2]`, is acknowledged by `sda_oe_o` = 1 during the ninth clock. Any other device byte gets no acknowledge, and later bytes are ignored until the next start.
- R3: Device byte bits 2:1 of a write form memory address bits 9:8. The word-address byte forms bits 7:0.
- R4: Every data byte of a write is acknowledged. A stop after at least one data byte commits the data to the array.
- R5: The address low 4 bits advance after each data byte and wrap inside the 16-byte page. Later bytes overwrite earlier bytes at the same offset.
- R6: After a commit, the target acknowledges no device byte for `BUSY_CYCLES` system clocks. After that it acknowledges again.
- R7: A device byte and word address with no data, followed by a repeated start and a read device byte, returns the byte at that address.
- R8: Read data leaves MSB first. The target keeps sending bytes while the controller acknowledges, and the address wraps from 1023 to 0.
- R9: A read with no preceding address uses the internal pointer, which holds the last accessed address plus one. The page bits of a read device byte are ignored.
- R10: With `wp_i` = 1, data bytes are still acknowledged, the array is unchanged, and no busy period starts.
- R11: A repeated start before a stop discards the staged write data. Nothing is committed and no busy period starts.
- R12: After reset, every array byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| sel_i | input | 3 | Hardwired select pins |
| wp_i | input | 1 | Write protect, 1 blocks array updates |

## Verification
Embedded properties check the following on every cycle:

- The data enable is never asserted during a busy period.
- The enable only moves while the synchronised clock is low.
- The page bits of the pointer stay fixed while data bytes arrive.
- A commit never starts while busy, and a busy period never follows a protected write.

Page wrap, rollover at the top of the array, discarding data on a repeated start, and the exact bytes returned can only be shown by the bench. It compares every acknowledge and every read byte against its own behavioural model of the array and the pointer.

// File: rtl/e2_pkg.sv
package e2_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } state_t;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;
endpackage

// File: rtl/e2_sync.sv
module e2_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    // index STAGES-1 is the synchronised level, STAGES the previous one
    assign scl_s_o    = scl_pipe[STAGES-1];
    assign sda_s_o    = sda_pipe[STAGES-1];
    assign scl_rise_o = scl_pipe[STAGES-1] & ~scl_pipe[STAGES];
    assign scl_fall_o = ~scl_pipe[STAGES-1] & scl_pipe[STAGES];
    assign start_o    = scl_pipe[STAGES-1] & scl_pipe[STAGES] &
                        sda_pipe[STAGES] & ~sda_pipe[STAGES-1];
    assign stop_o     = scl_pipe[STAGES-1] & scl_pipe[STAGES] &
                        ~sda_pipe[STAGES] & sda_pipe[STAGES-1];
endmodule

// File: rtl/e2_busy.sv
module e2_busy #(
    parameter int BUSY_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start_i) begin
            cnt <= CNT_W'(BUSY_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy_o = (cnt != '0);

    // R6: the engine must never launch a commit into a running busy period
    p_no_commit_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
endmodule

// File: rtl/e2_store.sv
module e2_store #(
    parameter int MEM_BYTES  = 1024,
    parameter int PAGE_BYTES = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_i,
    input  logic                           cap_i,
    input  logic [$clog2(PAGE_BYTES)-1:0]  cap_off_i,
    input  logic [7:0]                     cap_data_i,
    input  logic                           commit_i,
    input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] commit_page_i,
    input  logic [$clog2(MEM_BYTES)-1:0]   rd_addr_i,
    output logic [7:0]                     rd_data_o
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int OFF_W  = $clog2(PAGE_BYTES);

    logic [7:0]            mem   [MEM_BYTES];
    logic [7:0]            stage [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] filled;

    // one staging slot per page offset
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage[g]  <= 8'h00;
                filled[g] <= 1'b0;
            end else if (clr_i || commit_i) begin
                filled[g] <= 1'b0;
            end else if (cap_i && (cap_off_i == OFF_W'(g))) begin
                stage[g]  <= cap_data_i;
                filled[g] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < MEM_BYTES; a++) begin
                mem[a] <= 8'hFF;
            end
        end else if (commit_i) begin
            for (int s = 0; s < PAGE_BYTES; s++) begin
                if (filled[s]) begin
                    mem[{commit_page_i, OFF_W'(s)}] <= stage[s];
                end
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];

    // R4: a commit with nothing staged means the engine lost its data count
    p_commit_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> (filled != '0));

    initial begin
        if (ADDR_W <= OFF_W) $fatal(1, "array must hold more than one page");
    end
endmodule

// File: rtl/e2_target.sv
module e2_target
    import e2_pkg::*;
#(
    parameter int MEM_BYTES   = 1024,
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] sel_i,
    input  logic       wp_i
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int PG_W   = (ADDR_W > 8) ? ADDR_W - 8 : 0;
    localparam logic [2:0] PG_MASK = 3'((1 << PG_W) - 1);

    state_t state, nstate;

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic busy;

    logic [7:0]        sh;
    logic [3:0]        bitc;
    logic              rw;
    logic [2:0]        dev_pg;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        obuf;
    logic              m_ack;
    logic              have_data;
    logic [7:0]        rd_data;

    logic byte_done, dev_match, commit;

    e2_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s_o    (scl_s),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    assign byte_done = scl_fall && (bitc == BITS_PER_BYTE);
    assign dev_match = (sh[7:4] == DEV_PREFIX) &&
                       (((sh[3:1] ^ sel_i) & ~PG_MASK) == 3'b000);
    assign commit    = stop_ev && have_data && !wp_i && !busy;

    e2_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_i         (start_ev),
        .cap_i         ((state == ST_WDAT) && byte_done),
        .cap_off_i     (ptr[OFF_W-1:0]),
        .cap_data_i    (sh),
        .commit_i      (commit),
        .commit_page_i (ptr[ADDR_W-1:OFF_W]),
        .rd_addr_i     (ptr),
        .rd_data_o     (rd_data)
    );

    e2_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit),
        .busy_o  (busy)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // ---------------- next state ----------------
    always_comb begin
        nstate = state;
        if (start_ev) begin
            nstate = ST_DEV;
        end else if (stop_ev) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: nstate = state;
                ST_DEV:      if (byte_done) nstate = (dev_match && !busy) ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:  if (scl_fall)  nstate = rw ? ST_RD : ST_WADR;
                ST_WADR:     if (byte_done) nstate = ST_WADR_ACK;
                ST_WADR_ACK: if (scl_fall)  nstate = ST_WDAT;
                ST_WDAT:     if (byte_done) nstate = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall)  nstate = ST_WDAT;
                ST_RD:       if (byte_done) nstate = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)  nstate = m_ack ? ST_RD : ST_SKIP;
                default:     nstate = ST_IDLE;
            endcase
        end
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh        <= 8'h00;
            bitc      <= 4'd0;
            rw        <= 1'b0;
            dev_pg    <= 3'b000;
            ptr       <= '0;
            obuf      <= 8'hFF;
            m_ack     <= 1'b0;
            have_data <= 1'b0;
        end else if (start_ev || stop_ev) begin
            bitc      <= 4'd0;
            have_data <= 1'b0;
        end else begin
            unique case (state)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (scl_rise) begin
                        sh   <= {sh[6:0], sda_s};
                        bitc <= 4'(bitc + 1'b1);
                    end
                    if (byte_done) begin
                        bitc <= 4'd0;
                        if (state == ST_DEV) begin
                            rw     <= sh[0];
                            dev_pg <= sh[3:1];
                        end else if (state == ST_WADR) begin
                            ptr <= ADDR_W'({dev_pg & PG_MASK, sh});
                        end else begin
                            ptr       <= {ptr[ADDR_W-1:OFF_W], OFF_W'(ptr[OFF_W-1:0] + 1'b1)};
                            have_data <= 1'b1;
                        end
                    end
                end
                ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        bitc <= 4'd0;
                        if (state == ST_DEV_ACK && rw) obuf <= rd_data;
                    end
                end
                ST_RD: begin
                    if (scl_rise) bitc <= 4'(bitc + 1'b1);
                    if (byte_done) begin
                        bitc <= 4'd0;
                        ptr  <= ptr + 1'b1;
                    end else if (scl_fall) begin
                        obuf <= {obuf[6:0], 1'b1};
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) m_ack <= ~sda_s;
                    if (scl_fall && m_ack) obuf <= rd_data;
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK: sda_oe_o = 1'b1;
            ST_RD:                                sda_oe_o = ~obuf[7];
            default:                              sda_oe_o = 1'b0;
        endcase
    end

    // ---------------- properties ----------------
    // R6: silent for the whole programming period
    p_silent_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe_o);

    // R10: a busy period never follows a protected write
    p_wp_no_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp_i));

    // R8: the line is only moved while the serial clock is low
    p_oe_moves_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);

    // R5: page bits of the pointer stay fixed across a data byte
    p_page_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WDAT && state == ST_WDAT_ACK) |->
        (ptr[ADDR_W-1:OFF_W] == $past(ptr[ADDR_W-1:OFF_W])));

    initial begin
        if (ADDR_W > 11 || PAGE_W < 1) $fatal(1, "unsupported array size");
    end
endmodule

// File: tb/e2_target_tb.sv
module e2_target_tb;
    localparam int MEMB = 1024;
    localparam int BUSY = 2000;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic oe;
    logic bus_sda;

    always #2 clk = ~clk;

    assign bus_sda = m_sda & ~oe;

    e2_target #(.MEM_BYTES(MEMB), .PAGE_BYTES(16), .BUSY_CYCLES(BUSY)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (bus_sda),
        .sda_oe_o (oe),
        .sel_i    (3'b100),
        .wp_i     (wp)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int mem_m [MEMB];
    int ptr_m = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_cyc(input logic b, output logic seen);
        m_sda = b; wq();
        m_scl = 1'b1; wq();
        seen = bus_sda; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic do_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], s);
        bit_cyc(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cyc(1'b1, s);
            b[i] = s;
        end
        bit_cyc(~give_ack, s);
    endtask

    function automatic logic [7:0] devb(input int addr, input logic rd);
        return {4'b1010, 1'b1, 2'(addr >> 8), rd};
    endfunction

    // write n bytes starting at addr; model updates page-wrapped
    task automatic wr(input int addr, input int n, input int seed, input string req);
        logic a;
        do_start();
        send(devb(addr, 1'b0), a); chk({req, " dev ack"}, a, 1);
        send(8'(addr), a);         chk({req, " word ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            int tgt = (addr & ~15) | ((addr + i) & 15);
            send(8'(seed + i), a); chk({req, " data ack"}, a, 1);
            if (!wp) mem_m[tgt] = (seed + i) & 255;
        end
        do_stop();
        ptr_m = (addr & ~15) | ((addr + n) & 15);
    endtask

    task automatic rd_rand(input int addr, input int n, input string req);
        logic a;
        logic [7:0] b;
        do_start();
        send(devb(addr, 1'b0), a); chk({req, " dev ack"}, a, 1);
        send(8'(addr), a);         chk({req, " word ack"}, a, 1);
        do_start();
        send(devb(0, 1'b1), a);    chk({req, " rd dev ack"}, a, 1);
        ptr_m = addr;
        for (int i = 0; i < n; i++) begin
            recv(i != n - 1, b);
            chk({req, " data"}, int'(b), mem_m[ptr_m]);
            ptr_m = (ptr_m + 1) % MEMB;
        end
        do_stop();
    endtask

    task automatic poll(output int n);
        logic a;
        n = 0;
        a = 1'b0;
        while (!a && n < 40) begin
            do_start();
            send(devb(0, 1'b0), a);
            do_stop();
            n++;
        end
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        int np;
        for (int i = 0; i < MEMB; i++) mem_m[i] = 8'hFF;
        repeat (5) @(negedge clk);
        chk("R1 reset oe", int'(oe), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle oe", int'(oe), 0);

        // R12: erased contents
        rd_rand(12'h123, 1, "R12");

        // R2: wrong prefix, then trailing byte ignored
        do_start();
        send(8'hB0, a); chk("R2 bad prefix nack", a, 0);
        send(8'hAC, a); chk("R2 ignored until start", a, 0);
        // R1: a start recovers from the skip state
        do_start();
        send(8'hA0, a); chk("R2 select mismatch nack", a, 0);
        do_start();
        send(8'hA0 | 8'h08, a); chk("R1 start recovers", a, 1);
        do_stop();

        // R4/R3: byte write with page bits
        wr(12'h234, 1, 8'h5A, "R4");
        // R6: immediate poll not acknowledged, later acknowledged
        poll(np);
        chk("R6 first poll nack", int'(np > 1), 1);
        chk("R6 ack returns", int'(np < 40), 1);
        rd_rand(12'h234, 1, "R3 R7");

        // R5: page write across page end
        wr(12'h01E, 4, 8'h10, "R5");
        poll(np);
        // R9: current address read, page bits of read device ignored
        do_start();
        send({4'b1010, 1'b1, 2'b11, 1'b1}, a); chk("R9 cur dev ack", a, 1);
        recv(1'b0, b);
        chk("R9 current address data", int'(b), mem_m[ptr_m]);
        chk("R9 pointer value", ptr_m, 12'h012);
        do_stop();
        rd_rand(12'h01E, 2, "R5 tail");
        rd_rand(12'h010, 2, "R5 wrapped");

        // R8: rollover at the top of the array
        wr(12'h3FF, 1, 8'hC3, "R8 top");
        poll(np);
        wr(12'h000, 1, 8'h3C, "R8 bottom");
        poll(np);
        rd_rand(12'h3FE, 4, "R8 seq");

        // R10: write protect
        wp = 1'b1;
        wr(12'h234, 2, 8'h77, "R10");
        poll(np);
        chk("R10 no busy", np, 1);
        wp = 1'b0;
        rd_rand(12'h234, 2, "R10 unchanged");

        // R11: repeated start discards staged data
        do_start();
        send(devb(12'h040, 1'b0), a); chk("R11 dev ack", a, 1);
        send(8'h40, a);               chk("R11 word ack", a, 1);
        send(8'h99, a);               chk("R11 data ack", a, 1);
        do_start();
        send(devb(0, 1'b1), a);       chk("R11 rd dev ack", a, 1);
        recv(1'b0, b);
        chk("R11 read after discard", int'(b), mem_m[12'h041]);
        do_stop();
        poll(np);
        chk("R11 no busy", np, 1);
        rd_rand(12'h040, 1, "R11 not written");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule